// File: doc/BRIEF.md
# PHY Management Register File

This block gives a MAC the management view of a 10/100 Ethernet PHY without any serial management wiring. Software loads a target word that selects a PHY address and a register index. The block then returns the selected register on a read-data port, and a write strobe stores the write-data word into the selected register. Inside are a control word, a status word, an advertisement word, a link-partner ability word and two fixed identifier words.

A level input reports whether the link is up. The status word and the partner-ability word follow this input. Only accesses that carry the block's configured PHY address are served. Any other address reads as all ones and cannot write anything. Setting the reset bit in a control write reloads every default, and that bit always reads back as zero.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After reset the target word is 0x0000. The control word reads 0x3100: speed bit 13, auto-negotiation enable bit 12 and full-duplex bit 8 are set. The advertisement word reads 0x01E1. The PHY address parameter defaults to 0.
- R2: With the link down the status word (index 1) reads 0x7848. With the link up it reads 0x786C, which adds link bit 2 and auto-negotiation-complete bit 5.
- R3: With the link down the partner-ability word (index 5) reads 0x0080. With the link up it reads 0x01E0.
- R4: A change on `link_up` shows on `rd_data` from the cycle after the clock edge that samples it, and not before that edge.
- R5: While the address field of the target word differs from `PHY_ADDR`, `rd_data` is 0xFFFF.
- R6: A write while the address field differs from `PHY_ADDR` changes no register.
- R7: Writes to index 1 (status), index 2, index 3 (identifiers) and index 5 (partner ability) change nothing.
- R8: A control write (index 0) with bit 15 clear stores bits 14:0, and bit 15 reads as 0. An advertisement write (index 4) stores all 16 bits.
- R9: A control write with bit 15 set restores 0x3100 to the control word and 0x01E1 to the advertisement word. The other data bits are ignored, and the link-dependent bits keep following `link_up`.
- R10: Index 2 reads `ID_HI` and index 3 reads `ID_LO`. Any index above 5 at the matching address reads 0x0000.
- R11: The target word takes the PHY address from bits 15:8 and the register index from bits 7:0. A write uses the target value held before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link status level, 1 means the link is up |
| tgt_we | input | 1 | Loads `tgt_wdata` into the target word |
| tgt_wdata | input | 16 | New target word, address in 15:8 and index in 7:0 |
| wd_we | input | 1 | Writes `wd_data` to the targeted register |
| wd_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of the targeted register, or 0xFFFF |

## Verification
The read port is a combinational view of the target word, so a corrupted control or advertisement word shows at `rd_data` as soon as the target selects it. A lost link sample shows one cycle after `link_up` moves, in bits 2 and 5 of the status word and in bits 8:5 of the partner word. A write that leaks to a wrong address or to a read-only index stays hidden until that register is selected again. For that reason every write in the bench is followed by re-reading the register it must not have changed.

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs #(
  parameter logic [7:0]  PHY_ADDR = 8'd0,
  parameter logic [15:0] ID_HI    = 16'h7A11,
  parameter logic [15:0] ID_LO    = 16'h5C03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        tgt_we,
  input  logic [15:0] tgt_wdata,
  input  logic        wd_we,
  input  logic [15:0] wd_data,
  output logic [15:0] rd_data
);
  localparam logic [15:0] CTL_DEF = 16'h3100;
  localparam logic [15:0] ANA_DEF = 16'h01E1;
  localparam logic [15:0] ST_BASE = 16'h7848;
  localparam logic [15:0] ST_LINK = 16'h0024;
  localparam logic [15:0] LP_DOWN = 16'h0080;
  localparam logic [15:0] LP_UP   = 16'h01E0;

  logic [15:0] tgt_q, ctl_q, ana_q;
  logic        lnk_q;

  wire       hit = (tgt_q[15:8] == PHY_ADDR);
  wire [7:0] idx = tgt_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      ctl_q <= CTL_DEF;
      ana_q <= ANA_DEF;
      lnk_q <= 1'b0;
    end else begin
      lnk_q <= link_up;
      if (tgt_we) tgt_q <= tgt_wdata;
      if (wd_we && hit) begin
        case (idx)
          8'd0: begin
            if (wd_data[15]) begin
              ctl_q <= CTL_DEF;
              ana_q <= ANA_DEF;
            end else begin
              ctl_q <= {1'b0, wd_data[14:0]};
            end
          end
          8'd4:    ana_q <= wd_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (!hit) rd_data = 16'hFFFF;
    else begin
      case (idx)
        8'd0:    rd_data = ctl_q;
        8'd1:    rd_data = lnk_q ? (ST_BASE | ST_LINK) : ST_BASE;
        8'd2:    rd_data = ID_HI;
        8'd3:    rd_data = ID_LO;
        8'd4:    rd_data = ana_q;
        8'd5:    rd_data = lnk_q ? LP_UP : LP_DOWN;
        default: rd_data = 16'h0000;
      endcase
    end
  end
endmodule

module mii_mgmt_regs_chk #(
  parameter logic [7:0] PHY_ADDR = 8'd0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        tgt_we,
  input logic        wd_we,
  input logic [15:0] wd_data,
  input logic [15:0] tgt_q,
  input logic [15:0] rd_data
);
  AST_FOREIGN_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q[15:8] != PHY_ADDR) |-> (rd_data == 16'hFFFF)); // R5
  AST_LINK_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == {PHY_ADDR, 8'd1} && !tgt_we) |=> (rd_data[2] == $past(link_up) && rd_data[5] == $past(link_up))); // R4
  AST_CTL_RESET_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == {PHY_ADDR, 8'd0}) |-> !rd_data[15]); // R8
  AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == {PHY_ADDR, 8'd0} && wd_we && wd_data[15] && !tgt_we) |=> (rd_data == 16'h3100)); // R9
  AST_PARTNER_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == {PHY_ADDR, 8'd5} && wd_we && !tgt_we && link_up == $past(link_up)) |=> $stable(rd_data)); // R7
endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk #(.PHY_ADDR(PHY_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .tgt_we(tgt_we),
  .wd_we(wd_we), .wd_data(wd_data), .tgt_q(tgt_q), .rd_data(rd_data)
);

// File: tb/mii_mgmt_regs_tb_top.sv
module mii_mgmt_regs_tb_top;
  localparam logic [7:0] PA = 8'd5;
  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b0;
  logic tgt_we = 1'b0, wd_we = 1'b0;
  logic [15:0] tgt_wdata = '0, wd_data = '0, rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mii_mgmt_regs #(.PHY_ADDR(PA), .ID_HI(16'h7A11), .ID_LO(16'h5C03)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .tgt_we(tgt_we),
    .tgt_wdata(tgt_wdata), .wd_we(wd_we), .wd_data(wd_data), .rd_data(rd_data));

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic set_tgt(input logic [7:0] a, input logic [7:0] i);
    @(negedge clk); tgt_we = 1'b1; tgt_wdata = {a, i};
    @(negedge clk); tgt_we = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wd_we = 1'b1; wd_data = d;
    @(negedge clk); wd_we = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    #1 check("R1 target after reset", 16'hFFFF);
    set_tgt(PA, 8'd0); check("R1 control default", 16'h3100);
    set_tgt(PA, 8'd4); check("R1 advert default", 16'h01E1);
  endtask

  task automatic t_link;
    set_tgt(PA, 8'd1); check("R2 status down", 16'h7848);
    set_tgt(PA, 8'd5); check("R3 partner down", 16'h0080);
    set_tgt(PA, 8'd1);
    @(negedge clk); link_up = 1'b1; #1;
    check("R4 not before edge", 16'h7848);
    @(negedge clk); #1;
    check("R4 R2 status up", 16'h786C);
    set_tgt(PA, 8'd5); check("R3 partner up", 16'h01E0);
  endtask

  task automatic t_ids;
    set_tgt(PA, 8'd2); check("R10 id hi", 16'h7A11);
    set_tgt(PA, 8'd3); check("R10 id lo", 16'h5C03);
    set_tgt(PA, 8'd9); check("R10 unused index", 16'h0000);
  endtask

  task automatic t_writes;
    set_tgt(PA, 8'd0); wr(16'h0100); check("R8 control store", 16'h0100);
    wr(16'h4A5F); check("R8 control bits 14:0", 16'h4A5F);
    set_tgt(PA, 8'd4); wr(16'hBEEF); check("R8 advert store", 16'hBEEF);
    set_tgt(PA, 8'd0); wr(16'h8400); check("R9 control restored", 16'h3100);
    set_tgt(PA, 8'd4); check("R9 advert restored", 16'h01E1);
    set_tgt(PA, 8'd1); check("R9 link bits kept", 16'h786C);
  endtask

  task automatic t_readonly;
    set_tgt(PA, 8'd1); wr(16'h0000); check("R7 status read-only", 16'h786C);
    set_tgt(PA, 8'd5); wr(16'hFFFF); check("R7 partner read-only", 16'h01E0);
    set_tgt(PA, 8'd2); wr(16'h0000); check("R7 id hi read-only", 16'h7A11);
    set_tgt(PA, 8'd3); wr(16'h0000); check("R7 id lo read-only", 16'h5C03);
  endtask

  task automatic t_foreign;
    set_tgt(8'd6, 8'd0); check("R5 foreign address", 16'hFFFF);
    wr(16'h0000);
    set_tgt(8'd6, 8'd4); wr(16'h0000);
    set_tgt(PA, 8'd0); check("R6 control untouched", 16'h3100);
    set_tgt(PA, 8'd4); check("R6 advert untouched", 16'h01E1);
    set_tgt(8'd4, PA); check("R11 swapped fields", 16'hFFFF);
    @(negedge clk); tgt_we = 1'b1; tgt_wdata = {PA, 8'd4}; wd_we = 1'b1; wd_data = 16'h1234;
    @(negedge clk); tgt_we = 1'b0; wd_we = 1'b0; #1;
    check("R11 write used old target", 16'h01E1);
    @(negedge clk); link_up = 1'b0;
    @(negedge clk); set_tgt(PA, 8'd5); check("R3 partner down again", 16'h0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_link();
    t_ids();
    t_writes();
    t_readonly();
    t_foreign();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule